// File: doc/BRIEF.md
# Interrupt Status-Word Swap Sequencer

This block performs the context switch of a processor whose state is a single 64-bit status word. Requests arrive on one level line per interruption class. A class can be taken only when its enable bit in the current status word is set. When several enabled classes are pending together, the one with the lowest index wins. Each class owns two doubleword slots in memory. The sequencer writes the running status word, with the request's code placed in its code field, into the class's save slot. It then reads the class's handler slot and makes that doubleword the new status word. That one load changes both the instruction address and the mode bits.

The same engine runs the privileged load-status operation that returns from a handler. In supervisor state it reads one doubleword from the given address and installs it. In problem state it refuses the load and raises a privileged-operation program interruption. The memory side is a request/acknowledge doubleword port. Instruction fetch is held off for the whole sequence, and a one-cycle done pulse marks its end.

Top module: `intr_swap_seq`

Status-word layout: bits [59:56] are class enables (bit 56+i enables class i), bits [55:52] are the protection key, bit 48 is the problem-state bit, bits [47:32] are the interruption-code field and bits [31:0] are the instruction address. Class i has its save slot at byte address 0x40+16*i and its handler slot at 0x40+16*i+8.

## Requirements
- R1: After reset the status word is all zeros, and `fetchStall`, `swapDone`, `memReq` and `reqAck` are all 0.
- R2: In an idle cycle, the pending class with the lowest index whose enable bit (bit 56+i) is set is accepted. `reqAck` pulses one-hot for that class in that cycle.
- R3: A pending class whose enable bit is 0 gets no acknowledge and causes no memory traffic. It stays pending until a later status word sets its bit.
- R4: The first memory operation of an accepted interruption is a write to 0x40+16*i. Its data is the current status word with bits [47:32] replaced by the class's 16-bit code.
- R5: The next operation is a read of 0x40+16*i+8. The returned doubleword becomes the status word unchanged, including the instruction address, key, problem-state bit and enables.
- R6: `fetchStall` is 1 from the accepting clock edge until the edge that loads the new status word. `swapDone` is then 1 for exactly one cycle. The status word changes only on that load.
- R7: A load-status request (`lpswReq`) in an idle cycle with bit 48 equal to 0 causes exactly one read at `lpswAddr`, with no write. The returned doubleword becomes the status word.
- R8: A load-status request with bit 48 equal to 1 loads nothing. Instead, class 0 is entered whatever its enable bit: a write to 0x40 with code 0x0002, then a read of 0x48.
- R9: A handler status word that enables further pending classes lets them be taken right after the done pulse. The earlier handler is interrupted, in priority order.
- R10: `memReq`, `memWe`, `memAddr` and `memWdata` stay stable from the start of a request until the cycle that carries `memAck`.
- R11: When a load-status request and an enabled interruption are both present in the same idle cycle, the load-status request is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqPend | input | 4 | Pending level per class, held until acknowledged |
| reqCode | input | 64 | 16-bit interruption code per class, class i at [16i+15:16i] |
| reqAck | output | 4 | One-hot acceptance pulse |
| lpswReq | input | 1 | Load-status request, sampled only in idle cycles |
| lpswAddr | input | 16 | Byte address of the doubleword to load |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Doubleword byte address |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | One-cycle completion of the current request |
| memRdata | input | 64 | Read data, valid with `memAck` |
| statusWord | output | 64 | Current status word |
| fetchStall | output | 1 | Holds instruction fetch during a swap |
| swapDone | output | 1 | One-cycle pulse after the new status word is loaded |

## Verification
The assertions assume a well-behaved requester and memory. `memAck` arrives only while `memReq` is high and lasts one cycle. `lpswReq` is raised only while `fetchStall` is low, and a pending line drops only after its acknowledge. The bench's memory answers every request after a fixed latency with single-cycle acknowledges. It computes pending levels from raise and acknowledge counters, so a request is never withdrawn early. Load-status requests are issued only between sequences.

// File: rtl/iss_pkg.sv
package iss_pkg;
  localparam int SW_W     = 64;
  localparam int CODE_W   = 16;
  localparam int CODE_LSB = 32;
  localparam int PS_BIT   = 48;
  localparam int MASK_LSB = 56;

  typedef struct packed {
    logic capIntr;  // latch granted class and its code
    logic capPriv;  // latch program class with privileged-op code
    logic capLpsw;  // latch load-status address
    logic loadSw;   // install read data as status word
  } ctrlStrobes_t;
endpackage

// File: rtl/iss_arbiter.sv
module iss_arbiter #(
  parameter int NUM_CLASSES = 4,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic [NUM_CLASSES-1:0] pend,
  input  logic [NUM_CLASSES-1:0] enable,
  output logic [NUM_CLASSES-1:0] grantOh,
  output logic [CLS_W-1:0]       grantIdx,
  output logic                   anyGrant
);
  always_comb begin
    grantOh  = '0;
    grantIdx = '0;
    anyGrant = 1'b0;
    for (int i = NUM_CLASSES - 1; i >= 0; i--) begin
      if (pend[i] && enable[i]) begin
        grantOh    = '0;
        grantOh[i] = 1'b1;
        grantIdx   = CLS_W'(i);
        anyGrant   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iss_ctrl.sv
module iss_ctrl
  import iss_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lpswReq,
  input  logic         psBit,
  input  logic         anyGrant,
  input  logic         memAck,
  output ctrlStrobes_t strb,
  output logic         memReq,
  output logic         memWe,
  output logic         fetchStall,
  output logic         swapDone
);
  typedef enum logic [1:0] {S_IDLE, S_STORE_OLD, S_LOAD_NEW} state_t;
  state_t state, stateNxt;
  logic doneQ;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (lpswReq) begin
          if (psBit) begin
            strb.capPriv = 1'b1;
            stateNxt     = S_STORE_OLD;
          end else begin
            strb.capLpsw = 1'b1;
            stateNxt     = S_LOAD_NEW;
          end
        end else if (anyGrant) begin
          strb.capIntr = 1'b1;
          stateNxt     = S_STORE_OLD;
        end
      end
      S_STORE_OLD: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) stateNxt = S_LOAD_NEW;
      end
      S_LOAD_NEW: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.loadSw = 1'b1;
          stateNxt    = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNxt;
      doneQ <= strb.loadSw;
    end
  end

  assign fetchStall = (state != S_IDLE);
  assign swapDone   = doneQ;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    swapDone |=> !swapDone); // R6
  AST_DONE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    swapDone |-> !fetchStall && $past(fetchStall)); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memWe)); // R10
endmodule

// File: rtl/iss_datapath.sv
module iss_datapath
  import iss_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 16'h0040,
  parameter int PROG_CLASS = 0,
  parameter logic [CODE_W-1:0] PRIV_CODE = 16'h0002,
  parameter logic [SW_W-1:0] RESET_SW = '0,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strb,
  input  logic [CLS_W-1:0]              grantIdx,
  input  logic [NUM_CLASSES*CODE_W-1:0] reqCode,
  input  logic [ADDR_W-1:0]             lpswAddr,
  input  logic                          memReq,
  input  logic                          memWe,
  input  logic                          memAck,
  input  logic [SW_W-1:0]               memRdata,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [SW_W-1:0]               memWdata,
  output logic [SW_W-1:0]               statusWord
);
  localparam int SLOT_SHIFT = 4;  // 16 bytes per class: save then handler

  logic [CLS_W-1:0]  selClass;
  logic [CODE_W-1:0] selCode;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] saveAddr;
  logic [CLS_W-1:0]  nxtClass;

  function automatic logic [ADDR_W-1:0] slotAddr(input logic [CLS_W-1:0] cls);
    return SLOT_BASE + (ADDR_W'(cls) << SLOT_SHIFT);
  endfunction

  assign nxtClass = strb.capPriv ? CLS_W'(PROG_CLASS) : grantIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selClass   <= '0;
      selCode    <= '0;
      rdAddr     <= '0;
      statusWord <= RESET_SW;
    end else begin
      if (strb.capIntr || strb.capPriv) begin
        selClass <= nxtClass;
        selCode  <= strb.capPriv ? PRIV_CODE : reqCode[grantIdx*CODE_W +: CODE_W];
        rdAddr   <= slotAddr(nxtClass) + ADDR_W'(8);
      end
      if (strb.capLpsw) rdAddr <= lpswAddr;
      if (strb.loadSw)  statusWord <= memRdata;
    end
  end

  assign saveAddr = slotAddr(selClass);
  assign memAddr  = memWe ? saveAddr : rdAddr;

  always_comb begin
    memWdata = statusWord;
    memWdata[CODE_LSB +: CODE_W] = selCode;
  end

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr) && $stable(memWdata)); // R10
endmodule

// File: rtl/intr_swap_seq.sv
module intr_swap_seq
  import iss_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 16'h0040,
  parameter int PROG_CLASS = 0,
  parameter logic [CODE_W-1:0] PRIV_CODE = 16'h0002,
  parameter logic [SW_W-1:0] RESET_SW = '0,
  localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CLASSES-1:0]        reqPend,
  input  logic [NUM_CLASSES*CODE_W-1:0] reqCode,
  output logic [NUM_CLASSES-1:0]        reqAck,
  input  logic                          lpswReq,
  input  logic [ADDR_W-1:0]             lpswAddr,
  output logic                          memReq,
  output logic                          memWe,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [SW_W-1:0]               memWdata,
  input  logic                          memAck,
  input  logic [SW_W-1:0]               memRdata,
  output logic [SW_W-1:0]               statusWord,
  output logic                          fetchStall,
  output logic                          swapDone
);
  ctrlStrobes_t          strb;
  logic [NUM_CLASSES-1:0] grantOh;
  logic [NUM_CLASSES-1:0] enable;
  logic [CLS_W-1:0]       grantIdx;
  logic                   anyGrant;

  assign enable = statusWord[MASK_LSB +: NUM_CLASSES];

  iss_arbiter #(.NUM_CLASSES(NUM_CLASSES)) uArb (
    .pend(reqPend), .enable(enable), .grantOh(grantOh),
    .grantIdx(grantIdx), .anyGrant(anyGrant)
  );

  iss_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lpswReq(lpswReq), .psBit(statusWord[PS_BIT]),
    .anyGrant(anyGrant), .memAck(memAck), .strb(strb), .memReq(memReq),
    .memWe(memWe), .fetchStall(fetchStall), .swapDone(swapDone)
  );

  iss_datapath #(
    .NUM_CLASSES(NUM_CLASSES), .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE),
    .PROG_CLASS(PROG_CLASS), .PRIV_CODE(PRIV_CODE), .RESET_SW(RESET_SW)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .grantIdx(grantIdx), .reqCode(reqCode),
    .lpswAddr(lpswAddr), .memReq(memReq), .memWe(memWe), .memAck(memAck),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .statusWord(statusWord)
  );

  assign reqAck = strb.capIntr ? grantOh : '0;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqAck)); // R2
  AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck & ~(reqPend & enable)) == '0); // R3
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (|reqAck) |-> !fetchStall); // R2
  AST_STALL_MEM: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> fetchStall); // R6
  AST_SW_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !swapDone |-> $stable(statusWord)); // R6
endmodule

// File: tb/tb_intr_swap_seq.sv
`timescale 1ns/1ps
module tb_intr_swap_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  reqAck;
  logic [63:0] reqCode;
  logic        lpswReq = 1'b0;
  logic [15:0] lpswAddr = '0;
  logic        memReq, memWe, memAck;
  logic [15:0] memAddr;
  logic [63:0] memWdata, memRdata, statusWord;
  logic        fetchStall, swapDone;
  int          raiseCnt [4];
  int          ackCnt [4];
  logic [3:0]  reqPend;

  int nChecks = 0;
  int nFails = 0;
  int doneCnt = 0;

  always_comb
    for (int i = 0; i < 4; i++) reqPend[i] = (raiseCnt[i] != ackCnt[i]);

  assign reqCode = {16'h0C33, 16'h0B22, 16'h0A11, 16'h0900};

  intr_swap_seq dut (
    .clk(clk), .rstN(rstN), .reqPend(reqPend), .reqCode(reqCode), .reqAck(reqAck),
    .lpswReq(lpswReq), .lpswAddr(lpswAddr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .statusWord(statusWord), .fetchStall(fetchStall), .swapDone(swapDone)
  );

  typedef struct packed { logic we; logic [15:0] addr; logic [63:0] data; } memOp_t;
  memOp_t expQ[$];
  int     ackLog[$];
  logic [63:0] mem [64];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] en, input logic [3:0] key,
                                     input logic ps, input logic [31:0] ia);
    return {4'h0, en, key, 3'b000, ps, 16'h0000, ia};
  endfunction

  function automatic logic [63:0] ins(input logic [63:0] sw, input logic [15:0] code);
    logic [63:0] r = sw;
    r[47:32] = code;
    return r;
  endfunction

  function automatic logic [15:0] codeOf(input int c);
    return reqCode[c*16 +: 16];
  endfunction

  task automatic expWrite(input logic [15:0] a, input logic [63:0] d);
    expQ.push_back('{we: 1'b1, addr: a, data: d});
  endtask
  task automatic expRead(input logic [15:0] a);
    expQ.push_back('{we: 1'b0, addr: a, data: 64'h0});
  endtask

  // Memory responder and scoreboard monitor: fixed two-cycle latency.
  int waitCnt = 0;
  logic [15:0] hAddr;
  logic        hWe;
  logic [63:0] hData;
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      if (waitCnt == 0) begin hAddr <= memAddr; hWe <= memWe; hData <= memWdata; end
      if (waitCnt == 2) begin
        memOp_t e;
        waitCnt = 0;
        memAck <= 1'b1;
        check(memAddr == hAddr && memWe == hWe && memWdata == hData,
              "R10 request stable", {48'h0, memAddr}, {48'h0, hAddr});
        check(fetchStall == 1'b1, "R6 stall during memory op", 64'(fetchStall), 64'd1);
        if (expQ.size() == 0) begin
          check(1'b0, "R4/R5/R7 unexpected memory op", {47'h0, memWe, memAddr}, 64'h0);
        end else begin
          e = expQ.pop_front();
          check(memWe == e.we && memAddr == e.addr, "R4/R5/R7/R8 op order",
                {47'h0, memWe, memAddr}, {47'h0, e.we, e.addr});
          if (e.we)
            check(memWdata == e.data, "R4 saved word", memWdata, e.data);
        end
        if (memWe) mem[memAddr[8:3]] <= memWdata;
        else       memRdata <= mem[memAddr[8:3]];
      end else begin
        waitCnt = waitCnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (reqAck[i]) begin ackCnt[i] <= ackCnt[i] + 1; ackLog.push_back(i); end
    if (swapDone) doneCnt <= doneCnt + 1;
  end

  task automatic waitDones(input int n);
    int target = doneCnt + n;
    while (doneCnt < target) @(negedge clk);
    // doneCnt increments at the edge ending the pulse; status word is final
  endtask

  task automatic checkAcks(input string req, input int a0, input int a1, input int n);
    check(ackLog.size() == n, req, 64'(ackLog.size()), 64'(n));
    if (n > 0 && ackLog.size() > 0) check(ackLog[0] == a0, req, 64'(ackLog[0]), 64'(a0));
    if (n > 1 && ackLog.size() > 1) check(ackLog[1] == a1, req, 64'(ackLog[1]), 64'(a1));
    ackLog.delete();
  endtask

  task automatic doLpsw(input logic [15:0] a);
    lpswAddr = a;
    lpswReq = 1'b1;
    @(negedge clk);
    lpswReq = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 64'h0;
    for (int i = 0; i < 4; i++) begin raiseCnt[i] = 0; ackCnt[i] = 0; end
    memRdata = '0;
    mem[6'h20] = mk(4'b1110, 4'h3, 1'b0, 32'h0000_A000); // 0x100
    mem[6'h0D] = mk(4'b0000, 4'h5, 1'b0, 32'h0000_B000); // 0x68 class2 handler
    mem[6'h22] = mk(4'b1010, 4'h0, 1'b0, 32'h0000_C000); // 0x110
    mem[6'h0B] = mk(4'b1000, 4'h1, 1'b1, 32'h0000_D000); // 0x58 class1 handler
    mem[6'h0F] = mk(4'b0000, 4'h2, 1'b1, 32'h0000_E000); // 0x78 class3 handler
    mem[6'h24] = 64'hDEAD_BEEF_DEAD_BEEF;               // 0x120 must not load
    mem[6'h09] = mk(4'b0100, 4'h0, 1'b0, 32'h0000_6000); // 0x48 class0 handler
    mem[6'h26] = mk(4'b0100, 4'h7, 1'b0, 32'h0000_7000); // 0x130

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(statusWord == 64'h0, "R1 status word", statusWord, 64'h0);
    check(!fetchStall && !swapDone, "R1 stall/done", {62'h0, fetchStall, swapDone}, 64'h0);
    check(!memReq && reqAck == 4'h0, "R1 mem/ack", {59'h0, memReq, reqAck}, 64'h0);

    // R3 masked class stays pending
    raiseCnt[2]++;
    repeat (10) @(negedge clk);
    check(ackCnt[2] == 0 && !fetchStall, "R3 masked class not taken",
          64'(ackCnt[2]), 64'd0);
    check(reqPend[2] == 1'b1, "R3 still pending", 64'(reqPend[2]), 64'd1);

    // R7 load-status in supervisor state, then R3 class2 becomes enabled
    expRead(16'h0100);
    expWrite(16'h0060, ins(mk(4'b1110, 4'h3, 1'b0, 32'h0000_A000), codeOf(2)));
    expRead(16'h0068);
    doLpsw(16'h0100);
    check(fetchStall == 1'b1, "R6 stall after accept", 64'(fetchStall), 64'd1);
    waitDones(1);
    check(statusWord == mk(4'b1110, 4'h3, 1'b0, 32'h0000_A000), "R7 loaded word",
          statusWord, mk(4'b1110, 4'h3, 1'b0, 32'h0000_A000));
    waitDones(1);
    check(statusWord == mk(4'b0000, 4'h5, 1'b0, 32'h0000_B000), "R5 handler word",
          statusWord, mk(4'b0000, 4'h5, 1'b0, 32'h0000_B000));
    check(swapDone == 1'b0 && fetchStall == 1'b0, "R6 done single cycle",
          {62'h0, swapDone, fetchStall}, 64'h0);
    checkAcks("R3 class2 taken once enabled", 2, 0, 1);

    // R2/R9 simultaneous classes 1 and 3, handler of 1 enables 3
    raiseCnt[1]++;
    raiseCnt[3]++;
    repeat (4) @(negedge clk);
    check(!fetchStall, "R3 masked pair idle", 64'(fetchStall), 64'd0);
    expRead(16'h0110);
    expWrite(16'h0050, ins(mk(4'b1010, 4'h0, 1'b0, 32'h0000_C000), codeOf(1)));
    expRead(16'h0058);
    expWrite(16'h0070, ins(mk(4'b1000, 4'h1, 1'b1, 32'h0000_D000), codeOf(3)));
    expRead(16'h0078);
    doLpsw(16'h0110);
    waitDones(3);
    check(statusWord == mk(4'b0000, 4'h2, 1'b1, 32'h0000_E000), "R9 nested final word",
          statusWord, mk(4'b0000, 4'h2, 1'b1, 32'h0000_E000));
    checkAcks("R2 priority order", 1, 3, 2);

    // R8 load-status in problem state
    expWrite(16'h0040, ins(mk(4'b0000, 4'h2, 1'b1, 32'h0000_E000), 16'h0002));
    expRead(16'h0048);
    doLpsw(16'h0120);
    waitDones(1);
    check(statusWord == mk(4'b0100, 4'h0, 1'b0, 32'h0000_6000), "R8 program handler",
          statusWord, mk(4'b0100, 4'h0, 1'b0, 32'h0000_6000));
    checkAcks("R8 no request acknowledge", 0, 0, 0);

    // R11 load-status and enabled class2 in the same idle cycle
    expRead(16'h0130);
    expWrite(16'h0060, ins(mk(4'b0100, 4'h7, 1'b0, 32'h0000_7000), codeOf(2)));
    expRead(16'h0068);
    raiseCnt[2]++;
    doLpsw(16'h0130);
    waitDones(2);
    check(statusWord == mk(4'b0000, 4'h5, 1'b0, 32'h0000_B000), "R11 final word",
          statusWord, mk(4'b0000, 4'h5, 1'b0, 32'h0000_B000));
    checkAcks("R11 class2 after load", 2, 0, 1);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R4/R5 all expected ops seen", 64'(expQ.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule